// File: doc/BRIEF.md
# Activity-Aware Memory Request Arbiter

This block sits between a set of memory clients and the sequencers of eight 32-bit DRAM channels. Clients never address a channel directly. Each one pushes read or write requests into its own small queue at the arbiter. The arbiter looks at the head of every queue and decodes the target channel, bank and row from the address. It then forwards at most one request per cycle to the sequencer of the channel that owns the address.

The choice between competing heads combines two things. The first is a per-client priority that software sets. The second is how well each request fits what its channel did last: the same bank and row as the previous grant there, and the same transfer direction. Each kind of fit earns a bonus that software also sets. A low-priority request that fits can therefore beat a high-priority one that does not. A per-client starvation counter lifts a client that keeps losing to the maximum priority after a programmable number of losses. All of these parameters are written through a small register port and may change while traffic flows.

Top module: `mem_req_arbiter`

## Requirements
- R1: Each client has a two-entry queue. `req_ready` of a client is low while its queue holds two entries, and a request is taken only on a clock edge where `req_valid` and `req_ready` are both high.
- R2: Address bits [7:5] select the channel, bits [10:8] the bank and bits [23:11] the row. A grant raises only the `fwd_valid` bit of that channel and presents the client's address, write flag and client index unchanged on `fwd_addr`, `fwd_write` and `fwd_client`.
- R3: At most one `fwd_valid` bit is high in any cycle. A request whose channel has `chan_rdy` low cannot be chosen, and the arbiter picks among the remaining ones. The forward completes, and the queue entry leaves, in the same cycle as `fwd_valid`.
- R4: A request's score is the client priority (4 bits) plus the row bonus when its bank and row equal those of the last grant on its channel, plus the direction bonus when its write flag equals that of the last grant on its channel. The highest score wins.
- R5: When several requests have the highest score, the lowest client index wins.
- R6: A register write on `cfg_addr` below the client count sets that client's priority from `cfg_wdata[3:0]`. Address 0xC sets the row bonus from `cfg_wdata[3:0]`, address 0xD sets the direction bonus from `cfg_wdata[3:0]`, and address 0xE sets the starvation limit from `cfg_wdata[7:0]`. A new value affects arbitration from the next cycle.
- R7: A client loses a round when its queue head is valid and another client is granted. Once its count of losses since its last grant reaches a non-zero starvation limit, its priority counts as 15. A limit of 0 turns this off.
- R8: After reset, all queues are empty, all `req_ready` bits are high, no `fwd_valid` bit is set, all configuration values are 0 and no channel has a recorded activity.
- R9: Each grant records the bank, row and direction of the granted request as the activity of its channel, and the next cycle's scoring on that channel uses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Request valid, one bit per client |
| req_ready | output | 4 | Queue can accept, one bit per client |
| req_addr | input | 96 | Request address, 24 bits per client, client 0 in the low bits |
| req_write | input | 4 | 1 for a write, 0 for a read, per client |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| chan_rdy | input | 8 | Channel sequencer ready, one bit per channel |
| fwd_valid | output | 8 | Forward strobe, one-hot on the target channel |
| fwd_addr | output | 24 | Forwarded address |
| fwd_write | output | 1 | Forwarded direction |
| fwd_client | output | 2 | Index of the granted client |

## Verification
Two things can decide the same cycle's grant: the activity bonus computed from the channel's last grant, and the client priority or its starvation override. The bench parks requests by holding every channel not ready. It then opens the channels for half a cycle and reads the winner combinationally before closing them again. Between looks it changes one register, so a single queued pair shows the winner flipping as priority, row bonus and direction bonus are traded against each other. A continuous stream from a strong client against a single weak one shows the starvation override taking over on the exact grant that the limit predicts.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int ADDR_W    = 24;
  localparam int OFS_W     = 5;
  localparam int CHAN_W    = 3;
  localparam int BANK_W    = 3;
  localparam int ROW_W     = ADDR_W - OFS_W - CHAN_W - BANK_W;
  localparam int NUM_CHAN  = 1 << CHAN_W;
  localparam int PRIO_W    = 4;
  localparam int BONUS_W   = 4;
  localparam int SCORE_W   = PRIO_W + 2;
  localparam int CFG_AW    = 4;
  localparam int CFG_DW    = 8;
  localparam logic [CFG_AW-1:0] CFG_ROW_BONUS = 4'hC;
  localparam logic [CFG_AW-1:0] CFG_DIR_BONUS = 4'hD;
  localparam logic [CFG_AW-1:0] CFG_STARVE    = 4'hE;

  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic              write;
  } act_t;

  function automatic logic [CHAN_W-1:0] chan_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: CHAN_W];
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W+CHAN_W +: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: ROW_W];
  endfunction

  function automatic logic [SCORE_W-1:0] fit_score(
    input logic [PRIO_W-1:0]  prio,
    input act_t               act,
    input logic [BANK_W-1:0]  bank,
    input logic [ROW_W-1:0]   row,
    input logic               wr,
    input logic [BONUS_W-1:0] row_bonus,
    input logic [BONUS_W-1:0] dir_bonus);
    logic [SCORE_W-1:0] s;
    s = SCORE_W'(prio);
    if (act.valid && act.bank == bank && act.row == row) s = s + SCORE_W'(row_bonus);
    if (act.valid && act.write == wr) s = s + SCORE_W'(dir_bonus);
    return s;
  endfunction
endpackage

// File: rtl/mra_queue.sv
module mra_queue #(
  parameter int WIDTH = 25,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic             valid,
  output logic [WIDTH-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign valid   = (count != '0);
  assign dout    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/mra_cfg.sv
module mra_cfg
  import mra_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CFG_AW-1:0]     addr,
  input  logic [CFG_DW-1:0]     wdata,
  output logic [N*PRIO_W-1:0]   prio_flat,
  output logic [BONUS_W-1:0]    row_bonus,
  output logic [BONUS_W-1:0]    dir_bonus,
  output logic [CFG_DW-1:0]     starve_lim
);
  for (genvar i = 0; i < N; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n)                          prio_flat[i*PRIO_W +: PRIO_W] <= '0;
      else if (we && addr == CFG_AW'(i))   prio_flat[i*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_bonus  <= '0;
      dir_bonus  <= '0;
      starve_lim <= '0;
    end else if (we) begin
      if (addr == CFG_ROW_BONUS) row_bonus  <= wdata[BONUS_W-1:0];
      if (addr == CFG_DIR_BONUS) dir_bonus  <= wdata[BONUS_W-1:0];
      if (addr == CFG_STARVE)    starve_lim <= wdata;
    end
  end
endmodule

// File: rtl/mra_chan_act.sv
module mra_chan_act
  import mra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [CHAN_W-1:0] upd_chan,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic              upd_write,
  output act_t              act_o [NUM_CHAN],
  output logic [NUM_CHAN-1:0] act_valid
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_o[c] <= '0;
      end else if (upd && upd_chan == CHAN_W'(c)) begin
        act_o[c].valid <= 1'b1;
        act_o[c].bank  <= upd_bank;
        act_o[c].row   <= upd_row;
        act_o[c].write <= upd_write;
      end
    end
    assign act_valid[c] = act_o[c].valid;
  end
endmodule

// File: rtl/mra_pick.sv
module mra_pick
  import mra_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]         elig,
  input  logic [N*SCORE_W-1:0] score_flat,
  output logic                 gvalid,
  output logic [IDX_W-1:0]     gidx,
  output logic [SCORE_W-1:0]   gscore
);
  always_comb begin
    gvalid = 1'b0;
    gidx   = '0;
    gscore = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!gvalid || score_flat[i*SCORE_W +: SCORE_W] > gscore)) begin
        gvalid = 1'b1;
        gidx   = IDX_W'(i);
        gscore = score_flat[i*SCORE_W +: SCORE_W];
      end
    end
  end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
  import mra_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int QUEUE_DEPTH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CLIENTS-1:0]        req_valid,
  output logic [NUM_CLIENTS-1:0]        req_ready,
  input  logic [NUM_CLIENTS*ADDR_W-1:0] req_addr,
  input  logic [NUM_CLIENTS-1:0]        req_write,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [CFG_DW-1:0]             cfg_wdata,
  input  logic [NUM_CHAN-1:0]           chan_rdy,
  output logic [NUM_CHAN-1:0]           fwd_valid,
  output logic [ADDR_W-1:0]             fwd_addr,
  output logic                          fwd_write,
  output logic [$clog2(NUM_CLIENTS)-1:0] fwd_client
);
  localparam int IDX_W = $clog2(NUM_CLIENTS);
  localparam int ENT_W = ADDR_W + 1;
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

  // configuration
  logic [NUM_CLIENTS*PRIO_W-1:0] prio_flat;
  logic [BONUS_W-1:0]            row_bonus, dir_bonus;
  logic [CFG_DW-1:0]             starve_lim;

  mra_cfg #(.N(NUM_CLIENTS)) u_cfg (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .prio_flat, .row_bonus, .dir_bonus, .starve_lim
  );

  // named internal events
  logic                          grant_valid;
  logic [IDX_W-1:0]              grant_idx;
  logic [SCORE_W-1:0]            win_score;
  logic [CHAN_W-1:0]             grant_chan;
  logic [NUM_CLIENTS-1:0]        eligible;
  logic [NUM_CLIENTS-1:0]        head_valid;
  logic [NUM_CLIENTS-1:0]        starved;
  logic [NUM_CLIENTS-1:0]        pop;
  logic [NUM_CLIENTS*SCORE_W-1:0] score_flat;
  logic [ADDR_W-1:0]             head_addr  [NUM_CLIENTS];
  logic                          head_write [NUM_CLIENTS];
  logic [CHAN_W-1:0]             head_chan  [NUM_CLIENTS];

  act_t                          act [NUM_CHAN];
  logic [NUM_CHAN-1:0]           act_valid;

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_client
    logic [ENT_W-1:0]  q_dout;
    logic              q_full;
    logic [CFG_DW-1:0] lose_cnt;
    logic [PRIO_W-1:0] prio_eff;
    logic              lost;

    mra_queue #(.WIDTH(ENT_W), .DEPTH(QUEUE_DEPTH)) u_queue (
      .clk, .rst_n,
      .push (req_valid[i]),
      .din  ({req_write[i], req_addr[i*ADDR_W +: ADDR_W]}),
      .full (q_full),
      .pop  (pop[i]),
      .valid(head_valid[i]),
      .dout (q_dout)
    );

    assign req_ready[i]  = !q_full;
    assign head_addr[i]  = q_dout[ADDR_W-1:0];
    assign head_write[i] = q_dout[ADDR_W];
    assign head_chan[i]  = chan_of(q_dout[ADDR_W-1:0]);
    assign eligible[i]   = head_valid[i] && chan_rdy[head_chan[i]];
    assign pop[i]        = grant_valid && (grant_idx == IDX_W'(i));
    assign lost          = head_valid[i] && grant_valid && (grant_idx != IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)                   lose_cnt <= '0;
      else if (pop[i])              lose_cnt <= '0;
      else if (lost && lose_cnt != '1) lose_cnt <= lose_cnt + 1'b1;
    end

    assign starved[i] = (starve_lim != '0) && (lose_cnt >= starve_lim);
    assign prio_eff   = starved[i] ? PRIO_MAX : prio_flat[i*PRIO_W +: PRIO_W];

    assign score_flat[i*SCORE_W +: SCORE_W] =
      fit_score(prio_eff, act[head_chan[i]], bank_of(head_addr[i]),
                row_of(head_addr[i]), head_write[i], row_bonus, dir_bonus);
  end

  mra_pick #(.N(NUM_CLIENTS), .IDX_W(IDX_W)) u_pick (
    .elig(eligible), .score_flat, .gvalid(grant_valid), .gidx(grant_idx), .gscore(win_score)
  );

  assign grant_chan = head_chan[grant_idx];
  assign fwd_addr   = head_addr[grant_idx];
  assign fwd_write  = head_write[grant_idx];
  assign fwd_client = grant_idx;

  always_comb begin
    fwd_valid = '0;
    if (grant_valid) fwd_valid[grant_chan] = 1'b1;
  end

  mra_chan_act u_act (
    .clk, .rst_n,
    .upd      (grant_valid),
    .upd_chan (grant_chan),
    .upd_bank (bank_of(fwd_addr)),
    .upd_row  (row_of(fwd_addr)),
    .upd_write(fwd_write),
    .act_o    (act),
    .act_valid(act_valid)
  );
endmodule

// File: rtl/mra_checker.sv
module mra_checker
  import mra_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CHAN-1:0]  chan_rdy,
  input logic [NUM_CHAN-1:0]  fwd_valid,
  input logic                 grant_valid,
  input logic [IDX_W-1:0]     grant_idx,
  input logic [CHAN_W-1:0]    grant_chan,
  input logic [N-1:0]         eligible,
  input logic [N*SCORE_W-1:0] score_flat,
  input logic [SCORE_W-1:0]   win_score,
  input logic [NUM_CHAN-1:0]  act_valid
);
  AST_ONE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_valid)); // R3
  AST_FWD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid & ~chan_rdy) == '0); // R3
  AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> eligible[grant_idx]); // R3
  AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> act_valid[$past(grant_chan)]); // R9

  for (genvar i = 0; i < N; i++) begin : g_cli
    AST_BEST_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && eligible[i]) |-> score_flat[i*SCORE_W +: SCORE_W] <= win_score); // R4
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && eligible[i] && score_flat[i*SCORE_W +: SCORE_W] == win_score)
        |-> grant_idx <= IDX_W'(i)); // R5
  end
endmodule

bind mem_req_arbiter mra_checker #(.N(NUM_CLIENTS), .IDX_W(IDX_W)) u_chk (
  .clk, .rst_n, .chan_rdy, .fwd_valid, .grant_valid, .grant_idx, .grant_chan,
  .eligible, .score_flat, .win_score, .act_valid
);

// File: tb/test_mem_req_arbiter.sv
`timescale 1ns/1ps
module test_mem_req_arbiter;
  localparam int N = 4;
  localparam int AW = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req_valid = '0;
  logic [N-1:0]   req_ready;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]   req_write = '0;
  logic           cfg_we = 1'b0;
  logic [3:0]     cfg_addr = '0;
  logic [7:0]     cfg_wdata = '0;
  logic [7:0]     chan_rdy = '0;
  logic [7:0]     fwd_valid;
  logic [AW-1:0]  fwd_addr;
  logic           fwd_write;
  logic [1:0]     fwd_client;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mem_req_arbiter i_mem_req_arbiter (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write,
    .cfg_we, .cfg_addr, .cfg_wdata, .chan_rdy,
    .fwd_valid, .fwd_addr, .fwd_write, .fwd_client
  );

  function automatic logic [AW-1:0] mk(input int row, input int bank, input int ch);
    return {13'(row), 3'(bank), 3'(ch), 5'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int c, input logic [AW-1:0] a, input logic wr);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_addr[c*AW +: AW] = a;
    req_write[c] = wr;
    @(posedge clk); #1;
    req_valid[c] = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // open all channels for half a cycle, read the winner, close again
  task automatic peek(input string req, input int exp_client);
    @(negedge clk);
    chan_rdy = '1;
    #1;
    check(req, {31'd0, fwd_valid != 0}, 1);
    check(req, fwd_client, exp_client);
    chan_rdy = '0;
  endtask

  task automatic drain();
    @(negedge clk);
    chan_rdy = '1;
    repeat (5) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0_before;
    int c1_seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check("R8 fwd idle", fwd_valid, 0);
    check("R8 ready", req_ready, 4'hF);
    rst_n = 1'b1;

    // R1 queue full with channels closed
    push(0, mk(1, 0, 0), 0);
    check("R1 one entry", req_ready[0], 1);
    push(0, mk(2, 0, 0), 0);
    check("R1 full", req_ready[0], 0);
    check("R3 closed channel", fwd_valid, 0);
    drain();
    check("R1 drained", req_ready[0], 1);
    check("R3 drained idle", fwd_valid, 0);

    // R2 R9 decode sweep over every channel and direction
    for (int ch = 0; ch < 8; ch++) begin
      for (int wr = 0; wr < 2; wr++) begin
        logic [AW-1:0] a;
        a = mk(ch * 2 + wr + 1, ch, ch);
        push(0, a, wr[0]);
        check("R2 strobe", fwd_valid, 32'(1) << ch);
        check("R2 addr", fwd_addr, a);
        check("R2 write", fwd_write, wr);
        @(posedge clk); #1;
      end
    end

    // R3 channel 2 not ready, channel 5 ready
    chan_rdy = '0;
    cfg(4'h0, 8'd9);
    push(0, mk(1, 0, 2), 0);
    push(1, mk(1, 0, 5), 0);
    @(negedge clk);
    chan_rdy = 8'h20;
    #1;
    check("R3 only ready chan", fwd_valid, 8'h20);
    check("R3 client", fwd_client, 1);
    @(posedge clk); #1;
    check("R3 blocked stays", fwd_valid, 0);
    drain();

    // R4 R5 R6 plain priority and ties (no bonuses)
    chan_rdy = '0;
    cfg(4'h0, 8'd3);
    cfg(4'h1, 8'd7);
    push(0, mk(40, 1, 4), 0);
    push(1, mk(41, 1, 4), 0);
    peek("R4 prio 3 vs 7", 1);
    cfg(4'h1, 8'd3);
    peek("R5 tie 3 vs 3", 0);
    cfg(4'h0, 8'd2);
    peek("R6 reprogram 2 vs 3", 1);
    drain();

    // R4 R9 row bonus: prime channel 3 with bank 2 row 7 read
    push(0, mk(7, 2, 3), 0);
    @(posedge clk); #1;
    chan_rdy = '0;
    cfg(4'h0, 8'd5);
    cfg(4'h1, 8'd3);
    cfg(4'hC, 8'd4);
    cfg(4'hD, 8'd0);
    push(0, mk(9, 2, 3), 0);
    push(1, mk(7, 2, 3), 0);
    peek("R4 row hit 3+4 vs 5", 1);
    cfg(4'hC, 8'd1);
    peek("R4 row hit 3+1 vs 5", 0);
    drain(); // last grant: client 1, bank 2 row 7 read

    // R4 direction bonus on channel 3
    chan_rdy = '0;
    cfg(4'hC, 8'd0);
    cfg(4'hD, 8'd3);
    push(0, mk(1, 2, 3), 1);
    push(1, mk(2, 2, 3), 0);
    peek("R4 dir match 3+3 vs 5", 1);
    cfg(4'hD, 8'd2);
    peek("R5 dir tie 3+2 vs 5", 0);
    drain();

    // R7 starvation with limit 2
    chan_rdy = '0;
    cfg(4'hD, 8'd0);
    cfg(4'h0, 8'd9);
    cfg(4'h1, 8'd1);
    cfg(4'hE, 8'd2);
    push(1, mk(3, 0, 0), 0);
    push(0, mk(4, 0, 0), 0);
    push(0, mk(4, 0, 0), 0);
    @(negedge clk);
    req_valid[0] = 1'b1;
    chan_rdy = '1;
    c0_before = 0;
    c1_seen = 0;
    for (int k = 0; k < 8; k++) begin
      #1;
      if (c1_seen == 0 && fwd_valid != 0) begin
        if (fwd_client == 2'd1) c1_seen = 1;
        else c0_before++;
      end
      @(negedge clk);
    end
    check("R7 weak client wins", c1_seen, 1);
    check("R7 strong grants first", c0_before, 2);
    req_valid[0] = 1'b0;
    drain();

    // R7 limit 0 disables the override
    chan_rdy = '0;
    cfg(4'hE, 8'd0);
    push(1, mk(3, 0, 0), 0);
    push(0, mk(4, 0, 0), 0);
    push(0, mk(4, 0, 0), 0);
    @(negedge clk);
    req_valid[0] = 1'b1;
    chan_rdy = '1;
    c1_seen = 0;
    for (int k = 0; k < 6; k++) begin
      #1;
      if (fwd_valid != 0 && fwd_client == 2'd1) c1_seen = 1;
      @(negedge clk);
    end
    check("R7 disabled no override", c1_seen, 0);
    req_valid[0] = 1'b0;
    drain();
    check("R1 all ready at end", req_ready, 4'hF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule